// File: doc/BRIEF.md
# Display Video Packet Scheduler

This block produces the packet schedule of a serial display link running in video mode. From a set of timing settings (vertical line counts, horizontal blanking byte counts, the payload byte count of one line and the pixel packing format) it walks through a frame line by line. For each line it emits a short run of packet requests: a start-of-line or start-of-frame sync, optional sync blanking and sync end, blanking fill with a byte count, and either pixel payload or, outside the active region, blanking of the same length. Each request is a single-cycle strobe carrying a 6-bit data type and a byte count. A downstream packet builder turns the requests into lane traffic.

Three video schedules are supported: sync pulses with an explicit sync end, sync events with a single sync marker per line, and burst, where the payload goes out right after the sync marker and all of the line's remaining time becomes one blanking fill. Settings are captured at the start of each frame, so software may rewrite them at any time. When the mode input is set to command, the block completes the frame in progress, raises a one-cycle done strobe and falls silent.

Top module: `vid_pkt_sched`

## Requirements
- R1: The mode input uses 0 for command, 1 for sync-pulse video, 2 for sync-event video and 3 for burst video. While the block is idle and the mode is 0, no packet is issued. A nonzero mode starts a frame.
- R2: In sync-pulse mode each line is: line-start sync, blanking of the sync byte count, sync end (type 0x31), blanking of the back-porch count, the middle packet, and blanking of the front-porch count.
- R3: In sync-event mode each line is: line-start sync, back-porch blanking, the middle packet and front-porch blanking. No sync end and no sync blanking are issued.
- R4: In burst mode each line is: line-start sync, the middle packet, then one blanking packet whose count is the back-porch count plus the front-porch count.
- R5: A frame consists of the sync lines, then the back-porch lines, then the active lines, then the front-porch lines. Regions with a count of 0 are skipped. The first sync line starts with a frame-start sync (type 0x01). Every other line starts with a line-start sync (type 0x21).
- R6: On active lines the middle packet is pixel payload with the payload byte count. On all other lines it is blanking (type 0x19) with the same count.
- R7: The payload data type follows the format input: 0 (packed 16-bit) gives 0x0E, 1 (loose 18-bit) gives 0x2E, 2 (packed 18-bit) gives 0x1E, and 3 (packed 24-bit) gives 0x3E.
- R8: A blanking or payload packet whose byte count is 0 is not issued.
- R9: If the mode input is 0 when the last line of a frame completes, the block raises `vid_done` for exactly one cycle after that frame's last packet. It then issues no packet until the mode becomes nonzero again.
- R10: Every setting (mode, format, line counts, byte counts) is captured at frame start. Changes made during a frame do not affect that frame.
- R11: During and right after reset, `pkt_valid` and `vid_done` are low.
- R12: Sync packets (types 0x01, 0x21, 0x31) carry a byte count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Schedule select (0 command, 1 pulse, 2 event, 3 burst) |
| cfg_fmt | input | 2 | Pixel packing format |
| cfg_vsync_lines | input | V_W | Vertical sync line count |
| cfg_vback_lines | input | V_W | Vertical back-porch line count |
| cfg_vact_lines | input | V_W | Active line count |
| cfg_vfront_lines | input | V_W | Vertical front-porch line count |
| cfg_hsync_bytes | input | HB_W | Horizontal sync blanking bytes |
| cfg_hback_bytes | input | HB_W | Horizontal back-porch blanking bytes |
| cfg_hfront_bytes | input | HB_W | Horizontal front-porch blanking bytes |
| cfg_line_bytes | input | PS_W | Payload bytes per active line |
| pkt_valid | output | 1 | Packet request strobe |
| pkt_dt | output | 6 | Packet data type |
| pkt_wc | output | WC_W | Packet byte count |
| vid_done | output | 1 | Frame completed after switch to command |

## Verification
On every cycle, the assertions check the following: blanking never carries a zero count, sync packets carry no count, every issued data type is one of the legal codes, the done strobe lasts one cycle and is surrounded by silence, and reset keeps the outputs low. The ordering of packets within a line, the region order and skipping, the per-format payload type, the frame-start capture of the settings, and the completion of the current frame before done can only be shown by the bench. It runs whole frames over a sweep of modes, formats and vertical and horizontal sets, including zero counts, and rewrites the settings mid-frame.

// File: rtl/vts_pkg.sv
package vts_pkg;

  typedef enum logic [1:0] {
    MODE_CMD   = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_BURST = 2'd3
  } vmode_e;

  typedef enum logic [1:0] {
    REG_VSA  = 2'd0,
    REG_VBP  = 2'd1,
    REG_VACT = 2'd2,
    REG_VFP  = 2'd3
  } vregion_e;

  typedef enum logic [2:0] {
    SLOT_START   = 3'd0,
    SLOT_SYNCBLK = 3'd1,
    SLOT_SYNCEND = 3'd2,
    SLOT_BP      = 3'd3,
    SLOT_MID     = 3'd4,
    SLOT_TAIL    = 3'd5
  } slot_e;

  localparam logic [5:0] DT_FRAME_START = 6'h01;
  localparam logic [5:0] DT_LINE_START  = 6'h21;
  localparam logic [5:0] DT_SYNC_END    = 6'h31;
  localparam logic [5:0] DT_BLANK       = 6'h19;

  function automatic logic [5:0] payload_dt(input logic [1:0] fmt);
    case (fmt)
      2'd0:    payload_dt = 6'h0E;
      2'd1:    payload_dt = 6'h2E;
      2'd2:    payload_dt = 6'h1E;
      default: payload_dt = 6'h3E;
    endcase
  endfunction

endpackage

// File: rtl/vts_slot_map.sv
module vts_slot_map
  import vts_pkg::*;
#(
  parameter int HB_W = 12,
  parameter int PS_W = 14,
  parameter int WC_W = 14
) (
  input  slot_e             slot,
  input  vmode_e            mode,
  input  logic [1:0]        fmt,
  input  logic              first_vs,
  input  logic              act_line,
  input  logic [HB_W-1:0]   hsa,
  input  logic [HB_W-1:0]   hbp,
  input  logic [HB_W-1:0]   hfp,
  input  logic [PS_W-1:0]   line_bytes,
  output logic              emit,
  output logic [5:0]        dt,
  output logic [WC_W-1:0]   wc
);

  logic [WC_W-1:0] tail_wc;
  logic [WC_W-1:0] mid_wc;

  always_comb begin
    mid_wc = WC_W'(line_bytes);
    if (mode == MODE_BURST) tail_wc = WC_W'(hbp) + WC_W'(hfp);
    else                    tail_wc = WC_W'(hfp);
  end

  always_comb begin
    emit = 1'b0;
    dt   = DT_BLANK;
    wc   = '0;
    case (slot)
      SLOT_START: begin
        emit = 1'b1;
        dt   = first_vs ? DT_FRAME_START : DT_LINE_START;
      end
      SLOT_SYNCBLK: begin
        emit = (mode == MODE_PULSE) && (hsa != '0);
        wc   = WC_W'(hsa);
      end
      SLOT_SYNCEND: begin
        emit = (mode == MODE_PULSE);
        dt   = DT_SYNC_END;
      end
      SLOT_BP: begin
        emit = (mode != MODE_BURST) && (hbp != '0);
        wc   = WC_W'(hbp);
      end
      SLOT_MID: begin
        emit = (mid_wc != '0);
        dt   = act_line ? payload_dt(fmt) : DT_BLANK;
        wc   = mid_wc;
      end
      SLOT_TAIL: begin
        emit = (tail_wc != '0);
        wc   = tail_wc;
      end
      default: emit = 1'b0;
    endcase
  end

endmodule

// File: rtl/vts_line_gen.sv
module vts_line_gen
  import vts_pkg::*;
#(
  parameter int HB_W = 12,
  parameter int PS_W = 14,
  parameter int WC_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_req,
  input  logic              first_vs,
  input  logic              act_line,
  input  vmode_e            mode,
  input  logic [1:0]        fmt,
  input  logic [HB_W-1:0]   hsa,
  input  logic [HB_W-1:0]   hbp,
  input  logic [HB_W-1:0]   hfp,
  input  logic [PS_W-1:0]   line_bytes,
  output logic              line_done,
  output logic              pkt_valid,
  output logic [5:0]        pkt_dt,
  output logic [WC_W-1:0]   pkt_wc
);

  logic            busy;
  slot_e           slot;
  logic            s_emit;
  logic [5:0]      s_dt;
  logic [WC_W-1:0] s_wc;

  vts_slot_map #(.HB_W(HB_W), .PS_W(PS_W), .WC_W(WC_W)) map_i (
    .slot(slot), .mode(mode), .fmt(fmt), .first_vs(first_vs),
    .act_line(act_line), .hsa(hsa), .hbp(hbp), .hfp(hfp),
    .line_bytes(line_bytes), .emit(s_emit), .dt(s_dt), .wc(s_wc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      slot      <= SLOT_START;
      line_done <= 1'b0;
      pkt_valid <= 1'b0;
      pkt_dt    <= '0;
      pkt_wc    <= '0;
    end else begin
      line_done <= 1'b0;
      pkt_valid <= 1'b0;
      if (line_req) begin
        busy <= 1'b1;
        slot <= SLOT_START;
      end else if (busy) begin
        pkt_valid <= s_emit;
        if (s_emit) begin
          pkt_dt <= s_dt;
          pkt_wc <= s_wc;
        end
        if (slot == SLOT_TAIL) begin
          busy      <= 1'b0;
          line_done <= 1'b1;
        end else begin
          slot <= slot_e'(slot + 3'd1);
        end
      end
    end
  end

endmodule

// File: rtl/vts_frame_ctrl.sv
module vts_frame_ctrl
  import vts_pkg::*;
#(
  parameter int V_W  = 8,
  parameter int HB_W = 12,
  parameter int PS_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_in,
  input  logic [1:0]        fmt_in,
  input  logic [V_W-1:0]    vsa_in,
  input  logic [V_W-1:0]    vbp_in,
  input  logic [V_W-1:0]    vact_in,
  input  logic [V_W-1:0]    vfp_in,
  input  logic [HB_W-1:0]   hsa_in,
  input  logic [HB_W-1:0]   hbp_in,
  input  logic [HB_W-1:0]   hfp_in,
  input  logic [PS_W-1:0]   wc_in,
  input  logic              line_done,
  output logic              line_req,
  output logic              first_vs,
  output logic              act_line,
  output vmode_e            mode_q,
  output logic [1:0]        fmt_q,
  output logic [HB_W-1:0]   hsa_q,
  output logic [HB_W-1:0]   hbp_q,
  output logic [HB_W-1:0]   hfp_q,
  output logic [PS_W-1:0]   wc_q,
  output logic              vid_done
);

  localparam int NREG = 4;

  typedef enum logic [1:0] { F_IDLE, F_CHECK, F_WAIT } fst_e;

  fst_e           st;
  vregion_e       region;
  logic [V_W-1:0] lcnt;
  logic [V_W-1:0] vcnt_in [NREG];
  logic [V_W-1:0] vcnt_q  [NREG];
  logic           region_end;
  logic           frame_end;
  logic           latch_en;

  assign vcnt_in[0] = vsa_in;
  assign vcnt_in[1] = vbp_in;
  assign vcnt_in[2] = vact_in;
  assign vcnt_in[3] = vfp_in;

  assign region_end = (lcnt == vcnt_q[region]);
  assign frame_end  = (st == F_CHECK) && region_end && (region == REG_VFP);
  assign latch_en   = (mode_in != MODE_CMD) &&
                      ((st == F_IDLE) || frame_end);

  for (genvar g = 0; g < NREG; g++) begin : g_vlatch
    always_ff @(posedge clk) begin
      if (rst)           vcnt_q[g] <= '0;
      else if (latch_en) vcnt_q[g] <= vcnt_in[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_CMD;
      fmt_q  <= '0;
      hsa_q  <= '0;
      hbp_q  <= '0;
      hfp_q  <= '0;
      wc_q   <= '0;
    end else if (latch_en) begin
      mode_q <= vmode_e'(mode_in);
      fmt_q  <= fmt_in;
      hsa_q  <= hsa_in;
      hbp_q  <= hbp_in;
      hfp_q  <= hfp_in;
      wc_q   <= wc_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= F_IDLE;
      region   <= REG_VSA;
      lcnt     <= '0;
      line_req <= 1'b0;
      vid_done <= 1'b0;
    end else begin
      line_req <= 1'b0;
      vid_done <= 1'b0;
      case (st)
        F_IDLE: begin
          if (latch_en) begin
            region <= REG_VSA;
            lcnt   <= '0;
            st     <= F_CHECK;
          end
        end
        F_CHECK: begin
          if (region_end) begin
            lcnt <= '0;
            if (region == REG_VFP) begin
              region <= REG_VSA;
              if (mode_in == MODE_CMD) begin
                vid_done <= 1'b1;
                st       <= F_IDLE;
              end
            end else begin
              region <= vregion_e'(region + 2'd1);
            end
          end else begin
            line_req <= 1'b1;
            st       <= F_WAIT;
          end
        end
        F_WAIT: begin
          if (line_done) begin
            lcnt <= lcnt + 1'b1;
            st   <= F_CHECK;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign first_vs = (region == REG_VSA) && (lcnt == '0);
  assign act_line = (region == REG_VACT);

endmodule

// File: rtl/vid_pkt_sched.sv
module vid_pkt_sched
  import vts_pkg::*;
#(
  parameter int V_W  = 8,
  parameter int HB_W = 12,
  parameter int PS_W = 14,
  localparam int WC_W = (HB_W + 1 > PS_W) ? HB_W + 1 : PS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_fmt,
  input  logic [V_W-1:0]    cfg_vsync_lines,
  input  logic [V_W-1:0]    cfg_vback_lines,
  input  logic [V_W-1:0]    cfg_vact_lines,
  input  logic [V_W-1:0]    cfg_vfront_lines,
  input  logic [HB_W-1:0]   cfg_hsync_bytes,
  input  logic [HB_W-1:0]   cfg_hback_bytes,
  input  logic [HB_W-1:0]   cfg_hfront_bytes,
  input  logic [PS_W-1:0]   cfg_line_bytes,
  output logic              pkt_valid,
  output logic [5:0]        pkt_dt,
  output logic [WC_W-1:0]   pkt_wc,
  output logic              vid_done
);

  logic            line_req, line_done, first_vs, act_line;
  vmode_e          mode_q;
  logic [1:0]      fmt_q;
  logic [HB_W-1:0] hsa_q, hbp_q, hfp_q;
  logic [PS_W-1:0] wc_q;

  vts_frame_ctrl #(.V_W(V_W), .HB_W(HB_W), .PS_W(PS_W)) frame_i (
    .clk(clk), .rst(rst),
    .mode_in(cfg_mode), .fmt_in(cfg_fmt),
    .vsa_in(cfg_vsync_lines), .vbp_in(cfg_vback_lines),
    .vact_in(cfg_vact_lines), .vfp_in(cfg_vfront_lines),
    .hsa_in(cfg_hsync_bytes), .hbp_in(cfg_hback_bytes),
    .hfp_in(cfg_hfront_bytes), .wc_in(cfg_line_bytes),
    .line_done(line_done), .line_req(line_req),
    .first_vs(first_vs), .act_line(act_line),
    .mode_q(mode_q), .fmt_q(fmt_q),
    .hsa_q(hsa_q), .hbp_q(hbp_q), .hfp_q(hfp_q), .wc_q(wc_q),
    .vid_done(vid_done)
  );

  vts_line_gen #(.HB_W(HB_W), .PS_W(PS_W), .WC_W(WC_W)) line_i (
    .clk(clk), .rst(rst), .line_req(line_req),
    .first_vs(first_vs), .act_line(act_line),
    .mode(mode_q), .fmt(fmt_q),
    .hsa(hsa_q), .hbp(hbp_q), .hfp(hfp_q), .line_bytes(wc_q),
    .line_done(line_done),
    .pkt_valid(pkt_valid), .pkt_dt(pkt_dt), .pkt_wc(pkt_wc)
  );

endmodule

// File: rtl/vts_sched_checker.sv
module vts_sched_checker
  import vts_pkg::*;
#(
  parameter int WC_W = 14
) (
  input logic            clk,
  input logic            rst,
  input logic            pkt_valid,
  input logic [5:0]      pkt_dt,
  input logic [WC_W-1:0] pkt_wc,
  input logic            vid_done
);

  // R8: blanking is never issued empty
  p_blank_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_dt == DT_BLANK) |-> (pkt_wc != '0));

  // R12: sync packets carry no byte count
  p_sync_no_count_r12: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && (pkt_dt == DT_FRAME_START || pkt_dt == DT_LINE_START ||
                   pkt_dt == DT_SYNC_END)) |-> (pkt_wc == '0));

  // R7: only legal data types leave the block
  p_dt_legal_r7: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (pkt_dt == DT_FRAME_START || pkt_dt == DT_LINE_START ||
                   pkt_dt == DT_SYNC_END || pkt_dt == DT_BLANK ||
                   pkt_dt == 6'h0E || pkt_dt == 6'h1E ||
                   pkt_dt == 6'h2E || pkt_dt == 6'h3E));

  // R9: done lasts a single cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    vid_done |=> !vid_done);

  // R9: done coincides with and is followed by silence
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    vid_done |-> (!pkt_valid ##1 !pkt_valid));

  // R11: reset keeps the outputs low
  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (!pkt_valid && !vid_done));

endmodule

bind vid_pkt_sched vts_sched_checker #(.WC_W(WC_W)) chk_i (
  .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_dt(pkt_dt),
  .pkt_wc(pkt_wc), .vid_done(vid_done)
);

// File: tb/vid_pkt_sched_tb_top.sv
`timescale 1ns/1ps
module vid_pkt_sched_tb_top;

  localparam int V_W  = 8;
  localparam int HB_W = 12;
  localparam int PS_W = 14;
  localparam int WC_W = 14;
  localparam int MAXP = 512;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      cfg_mode = 2'd0;
  logic [1:0]      cfg_fmt = 2'd0;
  logic [V_W-1:0]  cfg_vsync_lines = '0, cfg_vback_lines = '0;
  logic [V_W-1:0]  cfg_vact_lines = '0, cfg_vfront_lines = '0;
  logic [HB_W-1:0] cfg_hsync_bytes = '0, cfg_hback_bytes = '0, cfg_hfront_bytes = '0;
  logic [PS_W-1:0] cfg_line_bytes = '0;
  logic            pkt_valid;
  logic [5:0]      pkt_dt;
  logic [WC_W-1:0] pkt_wc;
  logic            vid_done;

  always #10 clk = ~clk;

  vid_pkt_sched #(.V_W(V_W), .HB_W(HB_W), .PS_W(PS_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_fmt(cfg_fmt),
    .cfg_vsync_lines(cfg_vsync_lines), .cfg_vback_lines(cfg_vback_lines),
    .cfg_vact_lines(cfg_vact_lines), .cfg_vfront_lines(cfg_vfront_lines),
    .cfg_hsync_bytes(cfg_hsync_bytes), .cfg_hback_bytes(cfg_hback_bytes),
    .cfg_hfront_bytes(cfg_hfront_bytes), .cfg_line_bytes(cfg_line_bytes),
    .pkt_valid(pkt_valid), .pkt_dt(pkt_dt), .pkt_wc(pkt_wc),
    .vid_done(vid_done)
  );

  int checks = 0;
  int fails  = 0;

  logic [5:0] got_dt [MAXP];
  int         got_wc [MAXP];
  int         got_n = 0;
  int         done_n = 0;
  int         n_at_done = 0;
  logic [5:0] exp_dt [MAXP];
  int         exp_wc [MAXP];
  int         exp_n = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (pkt_valid && got_n < MAXP) begin
        got_dt[got_n] = pkt_dt;
        got_wc[got_n] = int'(pkt_wc);
        got_n = got_n + 1;
      end
      if (vid_done) begin
        done_n    = done_n + 1;
        n_at_done = got_n;
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic push(input logic [5:0] dt, input int wc);
    exp_dt[exp_n] = dt;
    exp_wc[exp_n] = wc;
    exp_n++;
  endtask

  function automatic logic [5:0] pay_dt(input int f);
    case (f)
      0: return 6'h0E;
      1: return 6'h2E;
      2: return 6'h1E;
      default: return 6'h3E;
    endcase
  endfunction

  // Expected frame from R2..R8
  task automatic build(input int m, input int f, input int vs, input int vb,
                       input int va, input int vf, input int hs, input int hb,
                       input int hf, input int lw);
    int cnt [4];
    cnt[0] = vs; cnt[1] = vb; cnt[2] = va; cnt[3] = vf;
    exp_n = 0;
    for (int r = 0; r < 4; r++) begin
      for (int l = 0; l < cnt[r]; l++) begin
        push((r == 0 && l == 0) ? 6'h01 : 6'h21, 0);
        if (m == 1) begin
          if (hs != 0) push(6'h19, hs);
          push(6'h31, 0);
        end
        if (m != 3 && hb != 0) push(6'h19, hb);
        if (lw != 0) push((r == 2) ? pay_dt(f) : 6'h19, lw);
        if (m == 3) begin
          if (hb + hf != 0) push(6'h19, hb + hf);
        end else if (hf != 0) push(6'h19, hf);
      end
    end
  endtask

  task automatic run_frame(input int m, input int f, input int vs, input int vb,
                           input int va, input int vf, input int hs, input int hb,
                           input int hf, input int lw);
    int w;
    int bad;
    string tag;
    build(m, f, vs, vb, va, vf, hs, hb, hf, lw);
    @(negedge clk);
    got_n = 0; done_n = 0; n_at_done = 0;
    cfg_fmt = 2'(f);
    cfg_vsync_lines = V_W'(vs); cfg_vback_lines = V_W'(vb);
    cfg_vact_lines = V_W'(va); cfg_vfront_lines = V_W'(vf);
    cfg_hsync_bytes = HB_W'(hs); cfg_hback_bytes = HB_W'(hb);
    cfg_hfront_bytes = HB_W'(hf); cfg_line_bytes = PS_W'(lw);
    cfg_mode = 2'(m);
    w = 0;
    while (got_n == 0 && w < 100) begin @(negedge clk); w++; end
    // R10: rewrite every setting mid-frame; R9: request command mode
    cfg_mode = 2'd0;
    cfg_fmt = 2'(f ^ 1);
    cfg_vsync_lines = V_W'(vs + 1); cfg_vback_lines = V_W'(vb + 1);
    cfg_vact_lines = V_W'(va + 1); cfg_vfront_lines = V_W'(vf + 1);
    cfg_hsync_bytes = HB_W'(hs + 3); cfg_hback_bytes = HB_W'(hb + 5);
    cfg_hfront_bytes = HB_W'(hf + 7); cfg_line_bytes = PS_W'(lw + 11);
    w = 0;
    while (done_n == 0 && w < 5000) begin @(negedge clk); w++; end
    repeat (20) @(negedge clk);
    tag = (m == 1) ? "R2" : (m == 2) ? "R3" : "R4";
    bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && (got_dt[i] != exp_dt[i] || got_wc[i] != exp_wc[i])) bad = i;
    check(got_n == exp_n, {tag, "/R5/R6/R8/R10 packet count"}, got_n, exp_n);
    if (bad >= 0)
      check(0, $sformatf("%s/R5/R6/R7/R8/R10/R12 packet %0d dt", tag, bad),
            int'(got_dt[bad]), int'(exp_dt[bad]));
    else
      check(1, "", 0, 0);
    if (bad >= 0)
      check(0, $sformatf("%s/R6/R10 packet %0d wc", tag, bad), got_wc[bad], exp_wc[bad]);
    check(done_n == 1, "R9 done pulse count", done_n, 1);
    check(n_at_done == exp_n, "R9 done after last packet", n_at_done, exp_n);
    check(got_n == n_at_done, "R9 silent after done", got_n, n_at_done);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pkt_valid == 1'b0, "R11 pkt_valid in reset", int'(pkt_valid), 0);
    check(vid_done == 1'b0, "R11 vid_done in reset", int'(vid_done), 0);
    rst = 1'b0;
    // R1: command mode while idle issues nothing
    cfg_vsync_lines = 1; cfg_vact_lines = 1; cfg_line_bytes = 6;
    repeat (40) @(negedge clk);
    check(got_n == 0, "R1 no packets in command mode", got_n, 0);
    check(done_n == 0, "R1 no done in command mode", done_n, 0);
    for (int m = 1; m <= 3; m++)
      for (int f = 0; f < 4; f++)
        for (int v = 0; v < 3; v++)
          for (int h = 0; h < 3; h++) begin
            int vs, vb, va, vf, hs, hb, hf, lw;
            case (v)
              0: begin vs = 1; vb = 1; va = 2; vf = 1; end
              1: begin vs = 2; vb = 0; va = 1; vf = 0; end
              default: begin vs = 1; vb = 2; va = 0; vf = 2; end
            endcase
            case (h)
              0: begin hs = 4; hb = 6; hf = 5; lw = 9; end
              1: begin hs = 0; hb = 0; hf = 3; lw = 0; end
              default: begin hs = 2; hb = 0; hf = 0; lw = 7; end
            endcase
            run_frame(m, f, vs, vb, va, vf, hs, hb, hf, lw);
          end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule